// File: doc/BRIEF.md
# Two-Channel Cascaded Biquad Equaliser

This block filters a stream of 24-bit signed samples belonging to two audio channels. The stream runs at twice the incoming sample rate. Each accepted sample passes through a fixed chain of slots. Slot 0 is a DC-blocking high-pass stage. Slots 1 to 8 are second-order IIR sections. Every slot is evaluated with one shared multiply-accumulate unit, one coefficient product per cycle. Each channel keeps its own delay history for each slot.

Coefficients are signed Q3.21 words, which cover the range from -4 up to just below +4. They are loaded one word at a time through a small write port into three banks: a user bank for each channel, and a shared tone bank that holds the fixed-role stages. Control inputs decide which slots run on each sample:

- A link bit makes both channels take every user stage from bank 0.
- Per-slot enable bits can turn slots 5 to 7 into user stages.
- Bypass bits skip the user stages.
- A crossover select field and a dual-band flag decide whether the last slot runs.

The control inputs are captured when a sample is accepted.

A sample enters with a one-cycle valid strobe, together with its channel bit. The filtered result comes back with a one-cycle done strobe after a fixed number of cycles, whatever slots were active.

Top module: `biquad_cascade`

## Requirements
- R1: After reset, every stored coefficient set is the identity (b0 = 0x200000, the other four words 0), and all delay state is zero. `out_valid` is low. With `hp_bypass` = 1, a sample leaves the block unchanged.
- R2: An active slot computes y = floor((b0·x + b1·x1 + b2·x2 + a1·y1 + a2·y2) / 2^21). The coefficients are signed Q3.21; a1 and a2 are added, so they are stored already negated. x1/x2 are the slot's last two inputs and y1/y2 its last two outputs, for the same channel. The slot's result feeds the next slot.
- R3: Each slot result saturates to the range -8388608 to 8388607.
- R4: An `in_valid` strobe seen while idle is accepted. Exactly 54 cycles later, `out_valid` is high for one cycle, with `out_ch` equal to the accepted channel. A strobe that arrives while a sample is in flight is ignored and leaves no trace.
- R5: Slot 0 runs when `hp_bypass` = 0. Its fixed coefficients are b0 = 1, b1 = -1, b2 = 0, a1 = 1 - 2^-8 (0x1FE000) and a2 = 0.
- R6: With `coef_link` = 0, slots 1 to 4 and slot 8 use the channel's own bank (bank 0 for channel 0, bank 1 for channel 1). Slots 5, 6 and 7 use tone-bank stages 0, 1 and 2 and always run. `slot_en` has no effect in this mode.
- R7: With `coef_link` = 1, every slot of both channels uses bank 0. Slots 5, 6 and 7 run only when `slot_en` bit 0, 1 or 2, respectively, is set.
- R8: Slot 8 runs only when `xover_sel` = 0 and `dualband_en` = 0.
- R9: `dsp_bypass` = 1, or `eq_bypass[c]` = 1, skips every user stage of channel c. Tone stages and slot 0 are unaffected.
- R10: A skipped slot passes its input through. Its delay state is held, and it resumes from that state when the slot is next active.
- R11: `cfg_we` writes `cfg_data` to word `cfg_sel` (0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2) of stage `cfg_stage` in bank `cfg_bank` (0 or 1 = user bank of that channel, 2 = tone bank). A write is ignored if `cfg_sel` > 4, if `cfg_bank` = 3, or if `cfg_bank` = 2 with `cfg_stage` > 2.
- R12: The two channels keep separate delay state. Samples of one channel do not alter the other channel's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 1 | Channel of the sample |
| in_sample | input | 24 | Signed input sample |
| hp_bypass | input | 1 | 1 skips the DC-blocking slot 0 |
| dsp_bypass | input | 1 | 1 skips the user stages of both channels |
| eq_bypass | input | 2 | Per-channel user-stage skip |
| coef_link | input | 1 | Both channels share bank 0 |
| slot_en | input | 3 | User enables for slots 5..7 when linked |
| xover_sel | input | 4 | Crossover select; nonzero takes slot 8 away |
| dualband_en | input | 1 | Dual-band compressor active; takes slot 8 away |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_bank | input | 2 | Target bank |
| cfg_stage | input | 3 | Target stage in the bank |
| cfg_sel | input | 3 | Target coefficient word |
| cfg_data | input | 24 | Q3.21 coefficient |
| out_valid | output | 1 | Done strobe |
| out_ch | output | 1 | Channel of the result |
| out_sample | output | 24 | Filtered signed sample |

## Verification
A bit-accurate fixed-point model drives the checks.

- An impulse followed by zeros exposes each programmed feed-forward and feedback tap separately.
- A sustained step shows the recursive state building up across four cascaded stages.
- Near-full-scale inputs with gains above 2 separate correct clipping from wrap-around.
- Alternating the channels with different banks shows whether delay histories are kept apart.
- Toggling link, enables, crossover and bypass in the middle of a sequence shows which bank each slot reads, and that a skipped slot's history is frozen and not cleared.

// File: rtl/bqc_pkg.sv
package bqc_pkg;
   localparam int NCOEF      = 5;
   localparam int TONE_FIRST = 5;
   localparam int TONE_LAST  = 7;
   localparam int N_TONE     = TONE_LAST - TONE_FIRST + 1;

   typedef enum logic [2:0] {
      K_B0 = 3'd0,
      K_B1 = 3'd1,
      K_B2 = 3'd2,
      K_A1 = 3'd3,
      K_A2 = 3'd4
   } coef_k_e;

   typedef enum logic [1:0] {
      BANK_CH0  = 2'd0,
      BANK_CH1  = 2'd1,
      BANK_TONE = 2'd2
   } bank_e;
endpackage

// File: rtl/bqc_slot_map.sv
module bqc_slot_map #(
   parameter int NUM_STAGES = 8
) (
   input  logic                ch,
   input  logic                link,
   input  logic                hp_bypass,
   input  logic                dsp_bypass,
   input  logic [1:0]          eq_bypass,
   input  logic [2:0]          slot_en,
   input  logic [3:0]          xover_sel,
   input  logic                dualband_en,
   output logic [NUM_STAGES:0] mask
);
   import bqc_pkg::*;

   logic user_on;
   logic xo_free;

   assign user_on = !dsp_bypass && !eq_bypass[ch];
   assign xo_free = (xover_sel == 4'd0) && !dualband_en;

   for (genvar s = 0; s <= NUM_STAGES; s++) begin : g_slot
      if (s == 0) begin : g_hp
         assign mask[s] = !hp_bypass;
      end else if (s < TONE_FIRST) begin : g_user
         assign mask[s] = user_on;
      end else if (s <= TONE_LAST) begin : g_tone
         assign mask[s] = link ? (slot_en[s-TONE_FIRST] && user_on) : 1'b1;
      end else begin : g_xo
         assign mask[s] = user_on && xo_free;
      end
   end
endmodule

// File: rtl/bqc_coef_bank.sv
module bqc_coef_bank #(
   parameter int COEF_W     = 24,
   parameter int COEF_FRAC  = 21,
   parameter int NUM_STAGES = 8,
   parameter int HP_SHIFT   = 8,
   localparam int STG_W     = $clog2(NUM_STAGES),
   localparam int SLOT_W    = $clog2(NUM_STAGES + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_bank,
   input  logic [STG_W-1:0]         wr_stage,
   input  logic [2:0]               wr_sel,
   input  logic [COEF_W-1:0]        wr_data,
   input  logic                     rd_ch,
   input  logic                     rd_link,
   input  logic [SLOT_W-1:0]        rd_slot,
   input  logic [2:0]               rd_k,
   output logic signed [COEF_W-1:0] rd_coef
);
   import bqc_pkg::*;

   localparam logic signed [COEF_W-1:0] ONE   = COEF_W'(1) <<< COEF_FRAC;
   localparam logic signed [COEF_W-1:0] HP_A1 = ONE - (COEF_W'(1) <<< (COEF_FRAC - HP_SHIFT));

   logic signed [COEF_W-1:0] ucoef [2][NUM_STAGES][NCOEF];
   logic signed [COEF_W-1:0] tcoef [N_TONE][NCOEF];
   logic [SLOT_W-1:0]        sidx, tidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++)
            for (int s = 0; s < NUM_STAGES; s++)
               for (int k = 0; k < NCOEF; k++)
                  ucoef[c][s][k] <= (k == 0) ? ONE : '0;
         for (int s = 0; s < N_TONE; s++)
            for (int k = 0; k < NCOEF; k++)
               tcoef[s][k] <= (k == 0) ? ONE : '0;
      end else if (wr_en && (wr_sel < 3'(NCOEF))) begin
         if (wr_bank == BANK_CH0 || wr_bank == BANK_CH1)
            ucoef[wr_bank[0]][wr_stage][wr_sel] <= wr_data;
         else if (wr_bank == BANK_TONE && wr_stage < STG_W'(N_TONE))
            tcoef[wr_stage[1:0]][wr_sel] <= wr_data;
      end
   end

   assign sidx = rd_slot - SLOT_W'(1);
   assign tidx = rd_slot - SLOT_W'(TONE_FIRST);

   always_comb begin
      rd_coef = '0;
      if (rd_k < 3'(NCOEF)) begin
         if (rd_slot == '0) begin
            case (rd_k)
               K_B0:    rd_coef = ONE;
               K_B1:    rd_coef = -ONE;
               K_A1:    rd_coef = HP_A1;
               default: rd_coef = '0;
            endcase
         end else if (!rd_link && rd_slot >= SLOT_W'(TONE_FIRST) && rd_slot <= SLOT_W'(TONE_LAST)) begin
            rd_coef = tcoef[tidx[1:0]][rd_k];
         end else begin
            rd_coef = ucoef[rd_link ? 1'b0 : rd_ch][sidx[STG_W-1:0]][rd_k];
         end
      end
   end
endmodule

// File: rtl/bqc_mac.sv
module bqc_mac #(
   parameter int DATA_W    = 24,
   parameter int COEF_W    = 24,
   parameter int COEF_FRAC = 21,
   parameter int GUARD     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [COEF_W-1:0] coef,
   input  logic signed [DATA_W-1:0] data,
   output logic signed [DATA_W-1:0] y
);
   localparam int PROD_W = DATA_W + COEF_W;
   localparam int ACC_W  = PROD_W + GUARD;
   localparam logic signed [ACC_W-1:0] YMAX = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] YMIN = -YMAX - ACC_W'(1);

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  acc_q, shifted;

   assign prod = coef * data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (en)  acc_q <= acc_q + prod;
   end

   assign shifted = acc_q >>> COEF_FRAC;

   always_comb begin
      if (shifted > YMAX)      y = YMAX[DATA_W-1:0];
      else if (shifted < YMIN) y = YMIN[DATA_W-1:0];
      else                     y = shifted[DATA_W-1:0];
   end
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade #(
   parameter int DATA_W     = 24,
   parameter int COEF_W     = 24,
   parameter int COEF_FRAC  = 21,
   parameter int NUM_STAGES = 8,
   parameter int GUARD      = 4,
   parameter int HP_SHIFT   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_ch,
   input  logic [DATA_W-1:0]             in_sample,
   input  logic                          hp_bypass,
   input  logic                          dsp_bypass,
   input  logic [1:0]                    eq_bypass,
   input  logic                          coef_link,
   input  logic [2:0]                    slot_en,
   input  logic [3:0]                    xover_sel,
   input  logic                          dualband_en,
   input  logic                          cfg_we,
   input  logic [1:0]                    cfg_bank,
   input  logic [$clog2(NUM_STAGES)-1:0] cfg_stage,
   input  logic [2:0]                    cfg_sel,
   input  logic [COEF_W-1:0]             cfg_data,
   output logic                          out_valid,
   output logic                          out_ch,
   output logic [DATA_W-1:0]             out_sample
);
   import bqc_pkg::*;

   localparam int NSLOT  = NUM_STAGES + 1;
   localparam int SLOT_W = $clog2(NSLOT);
   localparam int LAT    = NSLOT * (NCOEF + 1);
   localparam int CNT_W  = $clog2(LAT + 2);

   if (COEF_FRAC >= COEF_W || NUM_STAGES < TONE_LAST + 1 || GUARD < 3 || HP_SHIFT >= COEF_FRAC) begin : g_bad_cfg
      $error("biquad_cascade: illegal parameter combination");
   end

   logic                     busy_q, ch_q, link_q, start, wb, mac_en, mac_clr;
   logic [SLOT_W-1:0]        slot_q;
   logic [2:0]               ph_q;
   logic [NSLOT-1:0]         mask_q, mask_now;
   logic signed [DATA_W-1:0] cur_q, operand, mac_y;
   logic signed [COEF_W-1:0] coef;
   logic signed [DATA_W-1:0] sx1_q [2][NSLOT];
   logic signed [DATA_W-1:0] sx2_q [2][NSLOT];
   logic signed [DATA_W-1:0] sy1_q [2][NSLOT];
   logic signed [DATA_W-1:0] sy2_q [2][NSLOT];
   logic [CNT_W-1:0]         lat_cnt;

   assign start   = in_valid && !busy_q;
   assign wb      = busy_q && (ph_q == 3'(NCOEF));
   assign mac_en  = busy_q && (ph_q < 3'(NCOEF));
   assign mac_clr = start || wb;

   bqc_slot_map #(.NUM_STAGES(NUM_STAGES)) u_map (
      .ch(in_ch), .link(coef_link), .hp_bypass(hp_bypass), .dsp_bypass(dsp_bypass),
      .eq_bypass(eq_bypass), .slot_en(slot_en), .xover_sel(xover_sel),
      .dualband_en(dualband_en), .mask(mask_now)
   );

   bqc_coef_bank #(.COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .NUM_STAGES(NUM_STAGES),
                   .HP_SHIFT(HP_SHIFT)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_bank(cfg_bank), .wr_stage(cfg_stage),
      .wr_sel(cfg_sel), .wr_data(cfg_data), .rd_ch(ch_q), .rd_link(link_q),
      .rd_slot(slot_q), .rd_k(ph_q), .rd_coef(coef)
   );

   always_comb begin
      case (ph_q)
         3'd1:    operand = sx1_q[ch_q][slot_q];
         3'd2:    operand = sx2_q[ch_q][slot_q];
         3'd3:    operand = sy1_q[ch_q][slot_q];
         3'd4:    operand = sy2_q[ch_q][slot_q];
         default: operand = cur_q;
      endcase
   end

   bqc_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .GUARD(GUARD)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en),
      .coef(coef), .data(operand), .y(mac_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         ch_q       <= 1'b0;
         link_q     <= 1'b0;
         slot_q     <= '0;
         ph_q       <= '0;
         mask_q     <= '0;
         cur_q      <= '0;
         out_valid  <= 1'b0;
         out_ch     <= 1'b0;
         out_sample <= '0;
         for (int c = 0; c < 2; c++)
            for (int s = 0; s < NSLOT; s++) begin
               sx1_q[c][s] <= '0;
               sx2_q[c][s] <= '0;
               sy1_q[c][s] <= '0;
               sy2_q[c][s] <= '0;
            end
      end else begin
         out_valid <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            ch_q   <= in_ch;
            link_q <= coef_link;
            mask_q <= mask_now;
            cur_q  <= in_sample;
            slot_q <= '0;
            ph_q   <= '0;
         end else if (busy_q) begin
            if (!wb) begin
               ph_q <= ph_q + 3'd1;
            end else begin
               ph_q <= '0;
               if (mask_q[slot_q]) begin
                  sx2_q[ch_q][slot_q] <= sx1_q[ch_q][slot_q];
                  sx1_q[ch_q][slot_q] <= cur_q;
                  sy2_q[ch_q][slot_q] <= sy1_q[ch_q][slot_q];
                  sy1_q[ch_q][slot_q] <= mac_y;
                  cur_q               <= mac_y;
               end
               if (slot_q == SLOT_W'(NSLOT - 1)) begin
                  busy_q     <= 1'b0;
                  out_valid  <= 1'b1;
                  out_ch     <= ch_q;
                  out_sample <= mask_q[slot_q] ? mac_y : cur_q;
               end else begin
                  slot_q <= slot_q + SLOT_W'(1);
               end
            end
         end
      end
   end

   // Cycle count since acceptance, kept for the latency check.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (start)  lat_cnt <= '0;
      else if (busy_q) lat_cnt <= lat_cnt + CNT_W'(1);
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lat_cnt == CNT_W'(LAT)));                          // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);                                         // R4
   AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && in_valid) |=> (lat_cnt == $past(lat_cnt) + CNT_W'(1))); // R4
   AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wb && !mask_q[slot_q]) |=> $stable(cur_q));                       // R10
endmodule

// File: tb/test_biquad_cascade.sv
module test_biquad_cascade;
   localparam int LAT = 54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ch = 1'b0;
   logic [23:0] in_sample = '0;
   logic        hp_bypass = 1'b1, dsp_bypass = 1'b0, coef_link = 1'b0, dualband_en = 1'b0;
   logic [1:0]  eq_bypass = '0;
   logic [2:0]  slot_en = '0;
   logic [3:0]  xover_sel = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_bank = '0;
   logic [2:0]  cfg_stage = '0, cfg_sel = '0;
   logic [23:0] cfg_data = '0;
   logic        out_valid, out_ch;
   logic signed [23:0] out_sample;

   int n_chk = 0, n_fail = 0, cyc = 0;

   longint ucf [2][8][5];
   longint tcf [3][5];
   longint mx1 [2][9], mx2 [2][9], my1 [2][9], my2 [2][9];

   biquad_cascade i_biquad_cascade (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_sample(in_sample),
      .hp_bypass(hp_bypass), .dsp_bypass(dsp_bypass), .eq_bypass(eq_bypass),
      .coef_link(coef_link), .slot_en(slot_en), .xover_sel(xover_sel),
      .dualband_en(dualband_en), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
      .cfg_stage(cfg_stage), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .out_valid(out_valid), .out_ch(out_ch), .out_sample(out_sample)
   );

   always #4 clk = ~clk;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
         summary();
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic longint sat24(input longint v);
      if (v > 64'sd8388607)  return 64'sd8388607;
      if (v < -64'sd8388608) return -64'sd8388608;
      return v;
   endfunction

   function automatic bit active(input int ch, input int s);
      bit user_on;
      user_on = !dsp_bypass && !eq_bypass[ch];
      if (s == 0) return !hp_bypass;
      if (s <= 4) return user_on;
      if (s <= 7) return coef_link ? (slot_en[s-5] && user_on) : 1'b1;
      return user_on && xover_sel == 0 && !dualband_en;
   endfunction

   function automatic longint mcoef(input int ch, input int s, input int k);
      if (s == 0) begin
         if (k == 0) return 2097152;
         if (k == 1) return -2097152;
         if (k == 3) return 2088960;
         return 0;
      end
      if (!coef_link && s >= 5 && s <= 7) return tcf[s-5][k];
      return ucf[coef_link ? 0 : ch][s-1][k];
   endfunction

   function automatic longint model(input int ch, input longint xin);
      longint x, acc, y;
      x = xin;
      for (int s = 0; s < 9; s++) begin
         if (active(ch, s)) begin
            acc = mcoef(ch, s, 0) * x + mcoef(ch, s, 1) * mx1[ch][s] + mcoef(ch, s, 2) * mx2[ch][s]
                + mcoef(ch, s, 3) * my1[ch][s] + mcoef(ch, s, 4) * my2[ch][s];
            y = sat24(acc >>> 21);
            mx2[ch][s] = mx1[ch][s]; mx1[ch][s] = x;
            my2[ch][s] = my1[ch][s]; my1[ch][s] = y;
            x = y;
         end
      end
      return x;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hp_bypass = 1'b1; dsp_bypass = 1'b0; eq_bypass = '0; coef_link = 1'b0;
      slot_en = '0; xover_sel = '0; dualband_en = 1'b0; in_valid = 1'b0; cfg_we = 1'b0;
      for (int c = 0; c < 2; c++) begin
         for (int s = 0; s < 8; s++)
            for (int k = 0; k < 5; k++) ucf[c][s][k] = (k == 0) ? 2097152 : 0;
         for (int s = 0; s < 9; s++) begin
            mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
         end
      end
      for (int s = 0; s < 3; s++)
         for (int k = 0; k < 5; k++) tcf[s][k] = (k == 0) ? 2097152 : 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg(input int bank, input int stage, input int sel, input longint v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = bank[1:0]; cfg_stage = stage[2:0]; cfg_sel = sel[2:0];
      cfg_data = v[23:0];
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 5) begin
         if (bank < 2) ucf[bank][stage][sel] = v;
         else if (bank == 2 && stage < 3) tcf[stage][sel] = v;
      end
   endtask

   task automatic set_stage(input int bank, input int stage, input longint b0, input longint b1,
                            input longint b2, input longint a1, input longint a2);
      cfg(bank, stage, 0, b0); cfg(bank, stage, 1, b1); cfg(bank, stage, 2, b2);
      cfg(bank, stage, 3, a1); cfg(bank, stage, 4, a2);
   endtask

   task automatic send(input int ch, input longint x, input string req, output longint got);
      longint exp;
      bit seen;
      exp = model(ch, x);
      @(negedge clk);
      in_valid = 1'b1; in_ch = ch[0]; in_sample = x[23:0];
      seen = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (out_valid) seen = 1'b1;
      end
      got = longint'(out_sample);
      if (!seen) check({req, " done strobe"}, 0, 1);
      else begin
         check({req, " sample"}, got, exp);
         check({req, " channel"}, longint'(out_ch), ch);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      longint g;
      do_reset();
      check("R1 out_valid low after reset", longint'(out_valid), 0);
      send(0, 1234567, "R1 passthrough ch0", g);
      check("R1 identity value", g, 1234567);
      send(1, -8388608, "R1 passthrough ch1", g);
      check("R1 identity negative", g, -8388608);
   endtask

   task automatic t_latency();
      int n;
      bit seen;
      do_reset();
      @(negedge clk);
      in_valid = 1'b1; in_ch = 1'b1; in_sample = 24'd42;
      n = 0; seen = 1'b0;
      while (!seen && n < 200) begin
         @(negedge clk);
         in_valid = 1'b0;
         n++;
         if (out_valid) seen = 1'b1;
      end
      check("R4 latency edges", n, LAT + 1);
      check("R4 channel tag", longint'(out_ch), 1);
      @(negedge clk);
      check("R4 single-cycle strobe", longint'(out_valid), 0);
   endtask

   task automatic t_busy();
      longint g;
      int extra;
      bit seen;
      do_reset();
      set_stage(1, 0, 2097152, 0, 0, 1048576, 0);
      send(1, 100000, "R4 busy prep", g);
      g = model(0, 5000);
      @(negedge clk);
      in_valid = 1'b1; in_ch = 1'b0; in_sample = 24'd5000;
      seen = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         in_valid = (i == 9);
         in_ch = (i == 9);
         in_sample = (i == 9) ? 24'd777 : 24'd5000;
         if (out_valid) seen = 1'b1;
      end
      check("R4 in-flight result", longint'(out_sample), g);
      check("R4 in-flight channel", longint'(out_ch), 0);
      extra = 0;
      for (int i = 0; i < 70; i++) begin
         @(negedge clk);
         if (out_valid) extra++;
      end
      check("R4 ignored strobe gives no result", extra, 0);
      send(1, 0, "R4 ignored strobe leaves ch1 state", g);
      check("R4 ch1 echo value", g, 50000);
   endtask

   task automatic t_impulse();
      longint g;
      do_reset();
      set_stage(0, 0, 1048576, 524288, -262144, 1048576, -524288);
      set_stage(1, 0, 2097152, -1048576, 0, 0, 0);
      send(0, 1000000, "R2 impulse ch0 n0", g);
      check("R2 impulse first tap", g, 500000);
      send(1, 1000000, "R12 interleaved ch1", g);
      send(0, 0, "R2 impulse ch0 n1", g);
      check("R2 impulse second tap", g, 500000);
      send(1, 0, "R12 ch1 tail", g);
      check("R12 ch1 own history", g, -500000);
      for (int i = 2; i < 8; i++) send(0, 0, "R2 impulse tail ch0", g);
   endtask

   task automatic t_step();
      longint g;
      do_reset();
      set_stage(0, 0, 1048576, 0, 0, 1572864, -524288);
      set_stage(0, 1, 2097152, 2097152, 0, -1048576, 0);
      set_stage(0, 2, 1887437, -943718, 262144, 943718, -262144);
      set_stage(0, 3, 524288, 524288, 524288, 0, 0);
      for (int i = 0; i < 16; i++) send(0, 1048576, "R2 step cascade", g);
      for (int i = 0; i < 4; i++)  send(1, -700000, "R12 step ch1 identity", g);
   endtask

   task automatic t_sat();
      longint g;
      do_reset();
      set_stage(0, 0, 7340032, 0, 0, 0, 0);
      send(0, 6291456, "R3 positive clip", g);
      check("R3 positive clip value", g, 8388607);
      send(0, -6291456, "R3 negative clip", g);
      check("R3 negative clip value", g, -8388608);
      send(0, 100000, "R3 in-range", g);
      check("R3 in-range value", g, 350000);
   endtask

   task automatic t_hp();
      longint g;
      do_reset();
      hp_bypass = 1'b0;
      send(0, 4194304, "R5 dc block n0", g);
      check("R5 first output", g, 4194304);
      send(0, 4194304, "R5 dc block n1", g);
      check("R5 decay output", g, 4177920);
      for (int i = 0; i < 6; i++) send(0, 4194304, "R5 dc block decay", g);
      send(1, -3000000, "R5 ch1 step", g);
   endtask

   task automatic t_tone();
      longint g;
      do_reset();
      set_stage(2, 0, 1048576, 0, 0, 0, 0);
      set_stage(2, 2, 2097152, 1048576, 0, 0, 0);
      set_stage(0, 4, 524288, 0, 0, 0, 0);
      slot_en = 3'b111;
      send(0, 800000, "R6 tone stages ch0", g);
      check("R6 tone value", g, 400000);
      send(1, 800000, "R6 tone stages ch1", g);
      slot_en = 3'b000;
      send(0, 0, "R6 tone slot_en ignored", g);
      check("R6 tone tail value", g, 200000);
   endtask

   task automatic t_link();
      longint g;
      do_reset();
      set_stage(0, 4, 1048576, 0, 0, 0, 0);
      set_stage(1, 4, 524288, 0, 0, 0, 0);
      set_stage(2, 0, 4194304, 0, 0, 0, 0);
      set_stage(1, 0, 0, 0, 0, 0, 0);
      coef_link = 1'b1;
      slot_en = 3'b000;
      send(1, 600000, "R7 linked, slot5 off", g);
      check("R7 linked off value", g, 600000);
      slot_en = 3'b001;
      send(1, 600000, "R7 linked, slot5 on ch1", g);
      check("R7 linked on value", g, 300000);
      slot_en = 3'b110;
      send(0, 600000, "R7 linked, slots 6-7 on", g);
      coef_link = 1'b0;
      send(1, 600000, "R7 unlinked ch1 own bank", g);
      check("R7 unlinked zero gain", g, 0);
   endtask

   task automatic t_slot8();
      longint g;
      do_reset();
      set_stage(0, 7, 1048576, 0, 0, 0, 0);
      send(0, 400000, "R8 slot8 granted", g);
      check("R8 granted value", g, 200000);
      xover_sel = 4'd3;
      send(0, 400000, "R8 crossover takes slot8", g);
      check("R8 crossover value", g, 400000);
      xover_sel = 4'd0; dualband_en = 1'b1;
      send(0, 400000, "R8 dual-band takes slot8", g);
      check("R8 dual-band value", g, 400000);
   endtask

   task automatic t_bypass();
      longint g;
      do_reset();
      set_stage(0, 0, 2097152, 0, 0, 1048576, 0);
      set_stage(2, 1, 1048576, 0, 0, 0, 0);
      send(0, 1000000, "R9 prime ch0", g);
      eq_bypass = 2'b01;
      send(0, 1000000, "R9 eq bypass ch0 tone kept", g);
      check("R9 eq bypass value", g, 500000);
      send(1, 1000000, "R9 ch1 not bypassed", g);
      eq_bypass = 2'b00; dsp_bypass = 1'b1;
      send(1, 1000000, "R9 dsp bypass ch1", g);
      dsp_bypass = 1'b0;
      send(0, 0, "R10 resume held state", g);
      check("R10 resumed value", g, 250000);
   endtask

   task automatic t_cfg_ignore();
      longint g;
      do_reset();
      cfg(3, 0, 0, 0);
      cfg(0, 0, 5, 0);
      cfg(0, 0, 7, 0);
      cfg(2, 3, 0, 0);
      send(0, 321000, "R11 ignored writes ch0", g);
      check("R11 ignored value", g, 321000);
      cfg(1, 0, 0, 1048576);
      send(1, 321000, "R11 valid write ch1", g);
      check("R11 valid value", g, 160500);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_busy();
      t_impulse();
      t_step();
      t_sat();
      t_hp();
      t_tone();
      t_link();
      t_slot8();
      t_bypass();
      t_cfg_ignore();
      summary();
   end
endmodule